// File: doc/BRIEF.md
# Periodic Interrupt Divider and Status Flag Merger

This block turns a one-microsecond tick into a programmable periodic event and merges it with two external event pulses into one interrupt status byte. The periodic rate comes from a 4-bit field in a control byte. The interval between events is 1000000 divided by (65536 / 2^rate), in whole ticks. The accumulator keeps its remainder when it crosses the interval, so a shorter rate written later drains any excess count instead of discarding it.

Three event sources feed the status byte: the periodic event, an alarm pulse and an update pulse. Each source has an enable bit in a second control byte. A source whose enable bit is set raises a sticky flag. The request bit and the interrupt output follow the OR of the three flags. A single-cycle read strobe from the host side clears every flag.

Top module: `periodic_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, `stat_c` is 0x00 and `irq` is low.
- R2: With rate r = `stat_a[3:0]` in 1..15, a periodic event occurs on the tick that brings the accumulated tick count to 1000000 / (65536 >> r), using integer division. Rate 3 gives 122 ticks and rate 1 gives 30 ticks. `stat_a[7:4]` has no effect.
- R3: When an event occurs, the interval is subtracted from the accumulated count and the remainder is kept. After a switch to a shorter interval, events therefore repeat on every tick until the excess is used up.
- R4: Rate 0 produces no periodic event and holds the accumulator at zero. After a switch to a nonzero rate, the first event comes one full interval later.
- R5: The enable bits in `stat_b` are: bit 6 for periodic, bit 5 for alarm and bit 4 for update. An event whose enable bit is clear sets no flag and is not remembered.
- R6: The `stat_c` layout is: bit 6 periodic flag, bit 5 alarm flag, bit 4 update flag, bit 7 the OR of bits 6..4. Bits 3..0 always read 0.
- R7: `irq` is high exactly when `stat_c[7]` is high.
- R8: A `statc_rd` pulse clears all flags at the next clock edge. An enabled event in that same cycle still sets its flag.
- R9: Every flag stays set until a `statc_rd` pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per elapsed microsecond |
| stat_a | input | 8 | Control byte; bits 3:0 hold the periodic rate |
| stat_b | input | 8 | Control byte; bits 6..4 are the source enables |
| alarm_pulse | input | 1 | Alarm event from the time keeper |
| update_pulse | input | 1 | Update-complete event from the time keeper |
| statc_rd | input | 1 | Read strobe that clears the status flags |
| stat_c | output | 8 | Interrupt status byte |
| irq | output | 1 | Interrupt request |

## Verification
A wrong accumulator value cannot be seen directly. It shows up only as a periodic flag that appears earlier or later than one interval. After a rate change it can take a full long interval to show, so the bench runs a long interval and then a short one to expose a remainder that was reset. A flag register in the wrong state shows at `stat_c` and `irq` on the very next cycle. A reference model therefore compares the whole status byte on every clock.

// File: rtl/rtcirq_pkg.sv
// Package: shared constants and the interval computation for the periodic
// interrupt unit. Assumes the tick rate and the base frequency are positive.
package rtcirq_pkg;
    localparam int EN_PER_BIT = 6;   // status B enable for periodic source
    localparam int EN_ALM_BIT = 5;   // status B enable for alarm source
    localparam int EN_UPD_BIT = 4;   // status B enable for update source
    localparam int NUM_SRC    = 3;   // flag index 0 update, 1 alarm, 2 periodic

    // Interval in ticks for a rate code; zero means the rate is off.
    function automatic int unsigned period_of(int unsigned rate,
                                              int unsigned base_hz,
                                              int unsigned ticks_per_sec);
        int unsigned f;
        if (rate == 0) return 0;
        f = base_hz >> rate;
        if (f == 0) return 0;
        return ticks_per_sec / f;
    endfunction
endpackage

// File: rtl/rate_period_lut.sv
// Rate-to-interval lookup: one constant entry per rate code, built at
// elaboration time. Assumes every interval fits in ACC_W bits.
module rate_period_lut #(
    parameter int RATE_W        = 4,
    parameter int ACC_W         = 20,
    parameter int BASE_HZ       = 65536,
    parameter int TICKS_PER_SEC = 1000000
) (
    input  logic [RATE_W-1:0] rate,
    output logic [ACC_W-1:0]  period,
    output logic              rate_off
);
    localparam int N_RATES = 1 << RATE_W;

    logic [ACC_W-1:0] tbl [N_RATES];

    for (genvar gi = 0; gi < N_RATES; gi++) begin : g_entry
        localparam int unsigned P_VAL =
            rtcirq_pkg::period_of(gi, BASE_HZ, TICKS_PER_SEC);
        assign tbl[gi] = ACC_W'(P_VAL);
    end

    // Select the interval for the current rate code.
    always_comb begin
        period   = tbl[rate];
        rate_off = (period == '0);
    end
endmodule

// File: rtl/periodic_accum.sv
// Tick accumulator: counts ticks and fires when the count reaches the interval.
// On each event it subtracts the interval and keeps the remainder. Holds at
// zero while the rate is off.
module periodic_accum #(
    parameter int ACC_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rate_off,
    input  logic [ACC_W-1:0] period,
    output logic             evt
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   sum;
    logic [ACC_W:0]   rem;

    // Next count and event decision for this cycle.
    always_comb begin
        sum = {1'b0, acc} + {{ACC_W{1'b0}}, 1'b1};
        rem = sum - {1'b0, period};
        evt = tick && !rate_off && (sum >= {1'b0, period});
    end

    // Hold, clear or advance the accumulated count.
    always_ff @(posedge clk) begin
        if (!rst_n || rate_off) acc <= '0;
        else if (tick)          acc <= evt ? rem[ACC_W-1:0] : sum[ACC_W-1:0];
    end
endmodule

// File: rtl/flag_latch.sv
// Sticky source flag: set by an enabled event, cleared by the read strobe.
// A set in the same cycle as a clear wins.
module flag_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic en,
    input  logic clr,
    output logic q
);
    // Merge the clear and the new event into the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= (q && !clr) || (evt && en);
    end
endmodule

// File: rtl/periodic_irq_unit.sv
// Top: periodic interrupt divider plus the merge into the status byte.
// Assumes us_tick, alarm_pulse and update_pulse are one-cycle pulses.
module periodic_irq_unit #(
    parameter int RATE_W        = 4,
    parameter int ACC_W         = 20,
    parameter int BASE_HZ       = 65536,
    parameter int TICKS_PER_SEC = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic [7:0] stat_a,
    input  logic [7:0] stat_b,
    input  logic       alarm_pulse,
    input  logic       update_pulse,
    input  logic       statc_rd,
    output logic [7:0] stat_c,
    output logic       irq
);
    import rtcirq_pkg::*;

    logic [ACC_W-1:0]   period;
    logic               rate_off;
    logic               per_evt;
    logic [NUM_SRC-1:0] src_evt;
    logic [NUM_SRC-1:0] src_en;
    logic [NUM_SRC-1:0] flags;

    rate_period_lut #(.RATE_W(RATE_W), .ACC_W(ACC_W), .BASE_HZ(BASE_HZ),
                      .TICKS_PER_SEC(TICKS_PER_SEC)) i_lut (
        .rate(stat_a[RATE_W-1:0]), .period(period), .rate_off(rate_off));

    periodic_accum #(.ACC_W(ACC_W)) i_accum (
        .clk(clk), .rst_n(rst_n), .tick(us_tick), .rate_off(rate_off),
        .period(period), .evt(per_evt));

    // Gather event pulses and their enables in flag order.
    always_comb begin
        src_evt = {per_evt, alarm_pulse, update_pulse};
        src_en  = {stat_b[EN_PER_BIT], stat_b[EN_ALM_BIT], stat_b[EN_UPD_BIT]};
    end

    for (genvar gs = 0; gs < NUM_SRC; gs++) begin : g_src
        flag_latch i_flag (
            .clk(clk), .rst_n(rst_n), .evt(src_evt[gs]), .en(src_en[gs]),
            .clr(statc_rd), .q(flags[gs]));
    end

    // Assemble the status byte and the request line.
    always_comb begin
        stat_c = {|flags, flags, 4'b0000};
        irq    = |flags;
    end
endmodule

// File: rtl/periodic_irq_unit_chk.sv
// Checker for periodic_irq_unit: port-level temporal rules, bound to the top.
module periodic_irq_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] stat_a,
    input logic [7:0] stat_b,
    input logic       alarm_pulse,
    input logic       update_pulse,
    input logic       statc_rd,
    input logic [7:0] stat_c
);
    p_resv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_c[3:0] == 4'b0000);

    p_rate_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_a[3:0] == 4'd0 && !stat_c[6]) |=> !stat_c[6]);

    p_per_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_b[6] && !stat_c[6]) |=> !stat_c[6]);

    p_alm_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_b[5] && !stat_c[5]) |=> !stat_c[5]);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (statc_rd && !alarm_pulse && !update_pulse) |=> (stat_c[5:4] == 2'b00));

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_c[5] && !statc_rd) |=> stat_c[5]);
endmodule

bind periodic_irq_unit periodic_irq_unit_chk i_chk (
    .clk(clk), .rst_n(rst_n), .stat_a(stat_a), .stat_b(stat_b),
    .alarm_pulse(alarm_pulse), .update_pulse(update_pulse),
    .statc_rd(statc_rd), .stat_c(stat_c));

// File: tb/test_periodic_irq_unit.sv
module test_periodic_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b0;
    logic [7:0] stat_a = 8'h00;
    logic [7:0] stat_b = 8'h02;
    logic       alarm_pulse = 1'b0;
    logic       update_pulse = 1'b0;
    logic       statc_rd = 1'b0;
    logic [7:0] stat_c;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    int m_acc = 0;
    bit m_per = 0, m_alm = 0, m_upd = 0;

    always #5 clk = ~clk;

    periodic_irq_unit i_periodic_irq_unit (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .stat_a(stat_a),
        .stat_b(stat_b), .alarm_pulse(alarm_pulse), .update_pulse(update_pulse),
        .statc_rd(statc_rd), .stat_c(stat_c), .irq(irq));

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int interval(int r);
        if (r == 0) return 0;
        return 1000000 / (65536 >> r);
    endfunction

    // Behavioural reference, advanced on each clock edge.
    always @(posedge clk) begin
        bit ev;
        int p;
        ev = 0;
        if (!rst_n) begin
            m_acc = 0; m_per = 0; m_alm = 0; m_upd = 0;
        end else begin
            p = interval(int'(stat_a[3:0]));
            if (p == 0) m_acc = 0;
            else if (us_tick) begin
                m_acc = m_acc + 1;
                if (m_acc >= p) begin ev = 1; m_acc = m_acc - p; end
            end
            if (statc_rd) begin m_per = 0; m_alm = 0; m_upd = 0; end
            if (ev && stat_b[6])           m_per = 1;
            if (alarm_pulse && stat_b[5])  m_alm = 1;
            if (update_pulse && stat_b[4]) m_upd = 1;
        end
    end

    // Compare the status byte and request line every cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] e;
            e = {m_per | m_alm | m_upd, m_per, m_alm, m_upd, 4'b0000};
            chk(stat_c == e, "R6 R9 R3 stat_c vs model", int'(stat_c), int'(e));
            chk(irq == e[7], "R7 irq vs model", int'(irq), int'(e[7]));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Count cycles until the periodic flag shows; clears it on the first cycle.
    task automatic measure(output int n);
        n = 0;
        statc_rd = 1'b1;
        while (1) begin
            @(negedge clk);
            n++;
            #1 statc_rd = 1'b0;
            if (stat_c[6] || n > 2000) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk(stat_c == 8'h00, "R1 reset stat_c", int'(stat_c), 0);
        chk(irq == 1'b0, "R1 reset irq", int'(irq), 0);

        // R2: rate 3 interval, both from start and between events
        stat_b = 8'h42; stat_a = 8'h23; us_tick = 1'b1;
        n = 0;
        while (!stat_c[6] && n < 2000) begin @(negedge clk); n++; end
        #1;
        chk(n == 122, "R2 first interval rate 3", n, 122);
        stat_a = 8'hF3;
        measure(n);
        chk(n == 122, "R2 interval with upper bits set", n, 122);

        // R4: rate 0 stops and zeroes the accumulator
        stat_a = 8'h20; statc_rd = 1'b1; step(1); statc_rd = 1'b0;
        step(500);
        chk(stat_c[6] == 1'b0, "R4 no event at rate 0", int'(stat_c), 0);
        stat_a = 8'h23;
        n = 0;
        while (!stat_c[6] && n < 2000) begin @(negedge clk); n++; end
        #1;
        chk(n == 122, "R4 full interval after rate 0", n, 122);

        // R5: masked sources leave no flag
        stat_b = 8'h02; stat_a = 8'h21;
        statc_rd = 1'b1; step(1); statc_rd = 1'b0;
        alarm_pulse = 1'b1; update_pulse = 1'b1; step(1);
        alarm_pulse = 1'b0; update_pulse = 1'b0;
        step(100);
        chk(stat_c == 8'h00, "R5 masked sources", int'(stat_c), 0);

        // R6 R7 R9: alarm then update flags
        us_tick = 1'b0;
        stat_b = 8'h32;
        alarm_pulse = 1'b1; step(1); alarm_pulse = 1'b0; step(1);
        chk(stat_c == 8'hA0, "R6 alarm layout", int'(stat_c), 8'hA0);
        chk(irq == 1'b1, "R7 irq with alarm", int'(irq), 1);
        step(20);
        chk(stat_c == 8'hA0, "R9 alarm held", int'(stat_c), 8'hA0);
        update_pulse = 1'b1; step(1); update_pulse = 1'b0; step(1);
        chk(stat_c == 8'hB0, "R6 alarm and update", int'(stat_c), 8'hB0);

        // R8: clear with a coincident update event
        statc_rd = 1'b1; update_pulse = 1'b1; step(1);
        statc_rd = 1'b0; update_pulse = 1'b0; step(1);
        chk(stat_c == 8'h90, "R8 clear keeps same-cycle event", int'(stat_c), 8'h90);
        statc_rd = 1'b1; step(1); statc_rd = 1'b0; step(1);
        chk(stat_c == 8'h00, "R8 clear", int'(stat_c), 0);
        chk(irq == 1'b0, "R7 irq after clear", int'(irq), 0);

        // R3: long count, then a short interval drains the remainder
        stat_b = 8'h42; stat_a = 8'h2A; us_tick = 1'b1;
        step(10000);
        chk(stat_c[6] == 1'b0, "R3 no event before 15625", int'(stat_c), 0);
        stat_a = 8'h21; statc_rd = 1'b1;
        n = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (stat_c[6]) n++;
        end
        #1 statc_rd = 1'b0;
        chk(n == 300, "R3 remainder drains each tick", n, 300);

        // ticks every other cycle, model compares each cycle
        for (int i = 0; i < 200; i++) begin
            us_tick = (i % 2 == 0);
            statc_rd = (i % 37 == 0);
            step(1);
        end
        us_tick = 1'b0; statc_rd = 1'b0;
        step(5);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule